// File: doc/BRIEF.md
# Indirect Pixel-Buffer Descriptor Table

This block keeps a table of pixel-buffer descriptors that other engines use by index instead of by physical address. Each descriptor gives a buffer's base address and line stride, both counted in 8-byte units, along with its height, a wrap code, a tiling code and a byte-swap code. With the default parameters the table has 256 entries, so an entry index is 8 bits wide.

Software reaches the table only through three 32-bit registers on a simple single-cycle memory-mapped bus. Two of them are staging words that hold a descriptor in packed form; the stride field is split across the two words. The third is a command register. Writing it with the write flag set stores both staging words into the chosen entry in one step. Writing it with only the read flag set copies the chosen entry back into the staging words, where software can then read it. A separate lookup port lets a pixel engine read the decoded fields of any entry: it registers the index it is given and returns that entry's fields without a further register stage.

Register map, by byte offset: 0x00 is the low staging word, 0x04 the high staging word, 0x08 the command register. In the low word, bits 28:0 hold the base address and bits 31:29 hold stride bits 2:0. In the high word, bits 8:0 hold stride bits 11:3, bits 21:9 the height, bits 23:22 the wrap code (0 none, 1 X, 2 Y), bits 25:24 the tiling code (0 linear, 1 32x32, 2 64x64) and bits 29:26 the swap code (0x1, 0x3, 0x7 or 0xF for 16-, 32-, 64- or 128-bit swapping); bits 31:30 are unused. In the command register, bits 7:0 hold the index, bit 8 is the read flag and bit 9 the write flag.

Top module: `pixbuf_desc_table`

## Requirements
- R1: After reset both staging words read as zero, and every table entry, whether read through the lookup port or copied back with the read flag, is zero in every field.
- R2: A bus write to offset 0x00 or 0x04 sets that staging word, and a read returns it. High-word bits 31:30 always read as zero, and the command register at 0x08 reads as zero.
- R3: A write to 0x08 with bit 9 set stores the current low and high staging words into the entry selected by bits 7:0. From the next clock edge on, the lookup port shows the fields decoded from those words as laid out in the register map.
- R4: The lookup stride is the 12-bit value whose bits 2:0 come from low-word bits 31:29 and whose bits 11:3 come from high-word bits 8:0. This holds for all stride values, including 7, 8 and 0xFFF, and for entries 0 and 255.
- R5: A write to 0x08 with bit 8 set and bit 9 clear loads both staging words from the selected entry at that clock edge, so a read issued in the next cycle returns the entry's contents.
- R6: A write to 0x08 with both bit 8 and bit 9 set acts only as a commit. The staging words keep the values they held.
- R7: A write to 0x08 with bits 8 and 9 both clear changes neither the table nor the staging words.
- R8: The lookup port registers its index at each clock edge and shows the fields of the entry named by the registered index. Changing the index input does not change the outputs before the next edge, and a commit to the entry being shown appears on the outputs right after the commit edge.
- R9: A bus read is answered one cycle after it is issued, with read-valid high. When a read of 0x04 is issued in the cycle right after a commit, the table already holds the committed entry by the time the answer arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe, single cycle |
| bus_addr | input | 4 | Byte offset; accesses with bits 1:0 nonzero are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | High for one cycle, one cycle after bus_rd |
| lk_idx | input | 8 | Lookup entry index, registered inside the block |
| lk_base | output | 29 | Base address of the looked-up entry, 8-byte units |
| lk_stride | output | 12 | Line stride, 8-byte units |
| lk_height | output | 13 | Buffer height |
| lk_wrap | output | 2 | Wrap code |
| lk_tile | output | 2 | Tiling code |
| lk_swap | output | 4 | Byte-swap code |

## Verification
Two functions can land on the same clock edge: a commit from the bus and the lookup port showing the entry being committed. The bench holds the lookup index on one entry, checks that the old fields are still shown while the commit write is on the bus, and checks that the new fields are shown after that edge. It then checks that the high-word read issued right after the commit returns while the lookup already shows the new entry. A second collision is a command write with both flags set. There the store must happen and the copy-back must not; the bench shows this by first loading the staging words with values that differ from the target entry's old contents and then reading them back.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  parameter int WORD_W      = 32;
  parameter int BASE_W      = 29;
  parameter int STRIDE_W    = 12;
  parameter int STRIDE_LO_W = WORD_W - BASE_W;
  parameter int STRIDE_HI_W = STRIDE_W - STRIDE_LO_W;
  parameter int HEIGHT_W    = 13;
  parameter int WRAP_W      = 2;
  parameter int TILE_W      = 2;
  parameter int SWAP_W      = 4;
  parameter int HEIGHT_LSB  = STRIDE_HI_W;
  parameter int WRAP_LSB    = HEIGHT_LSB + HEIGHT_W;
  parameter int TILE_LSB    = WRAP_LSB + WRAP_W;
  parameter int SWAP_LSB    = TILE_LSB + TILE_W;
  parameter int HI_USED_W   = SWAP_LSB + SWAP_W;
  parameter int ENTRY_W     = WORD_W + HI_USED_W;

  typedef enum logic [1:0] {
    SEL_LO  = 2'd0,
    SEL_HI  = 2'd1,
    SEL_CMD = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [BASE_W-1:0]   base;
    logic [STRIDE_W-1:0] stride;
    logic [HEIGHT_W-1:0] height;
    logic [WRAP_W-1:0]   wrap;
    logic [TILE_W-1:0]   tile;
    logic [SWAP_W-1:0]   swap;
  } desc_t;
endpackage

// File: rtl/pbd_stage_regs.sv
module pbd_stage_regs
  import pbd_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  output logic               bus_rvalid,
  output logic               commit,
  output logic [IDX_W-1:0]   cmd_idx,
  output logic [ENTRY_W-1:0] stage_word,
  input  logic [ENTRY_W-1:0] fetch_word
);
  localparam int RD_BIT = IDX_W;
  localparam int WR_BIT = IDX_W + 1;

  logic [WORD_W-1:0]    stage_lo;
  logic [HI_USED_W-1:0] stage_hi;
  reg_sel_e             sel;
  logic                 cmd_wr;
  logic                 load_back;

  always_comb begin
    sel = SEL_NONE;
    if (bus_addr[1:0] == 2'b00) begin
      case (bus_addr[ADDR_W-1:2])
        0:       sel = SEL_LO;
        1:       sel = SEL_HI;
        2:       sel = SEL_CMD;
        default: sel = SEL_NONE;
      endcase
    end
  end

  assign cmd_wr     = bus_wr && (sel == SEL_CMD);
  assign commit     = cmd_wr && bus_wdata[WR_BIT];
  assign load_back  = cmd_wr && bus_wdata[RD_BIT] && !bus_wdata[WR_BIT];
  assign cmd_idx    = bus_wdata[IDX_W-1:0];
  assign stage_word = {stage_hi, stage_lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
      stage_hi <= '0;
    end else if (load_back) begin
      stage_lo <= fetch_word[WORD_W-1:0];
      stage_hi <= fetch_word[ENTRY_W-1:WORD_W];
    end else if (bus_wr && sel == SEL_LO) begin
      stage_lo <= bus_wdata;
    end else if (bus_wr && sel == SEL_HI) begin
      stage_hi <= bus_wdata[HI_USED_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd;
      if (bus_rd) begin
        case (sel)
          SEL_LO:  bus_rdata <= stage_lo;
          SEL_HI:  bus_rdata <= {{(WORD_W-HI_USED_W){1'b0}}, stage_hi};
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  // R6
  both_flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[RD_BIT] && bus_wdata[WR_BIT]) |=> ($stable(stage_lo) && $stable(stage_hi)));

  // R7
  idle_cmd_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !bus_wdata[RD_BIT] && !bus_wdata[WR_BIT]) |=> ($stable(stage_lo) && $stable(stage_hi)));

  // R9
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid);

  // R2
  hi_unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rvalid && $past(sel) != SEL_LO) |-> (bus_rdata[WORD_W-1:HI_USED_W] == '0));
endmodule

// File: rtl/pbd_entry_store.sv
module pbd_entry_store
  import pbd_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   a_idx,
  output logic [ENTRY_W-1:0] a_data,
  input  logic [IDX_W-1:0]   b_idx,
  output logic [ENTRY_W-1:0] b_data
);
  logic [ENTRY_W-1:0] mem [ENTRIES];
  logic [ENTRIES-1:0] filled;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) filled <= '0;
    else if (wr_en) filled[wr_idx] <= 1'b1;
  end

  assign a_data = filled[a_idx] ? mem[a_idx] : '0;
  assign b_data = filled[b_idx] ? mem[b_idx] : '0;

  // R3
  commit_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> filled[$past(wr_idx)]);
endmodule

// File: rtl/pbd_field_decode.sv
module pbd_field_decode
  import pbd_pkg::*;
(
  input  logic [ENTRY_W-1:0] word,
  output desc_t              desc
);
  logic [WORD_W-1:0]    lo;
  logic [HI_USED_W-1:0] hi;

  assign lo = word[WORD_W-1:0];
  assign hi = word[ENTRY_W-1:WORD_W];

  always_comb begin
    desc.base   = lo[BASE_W-1:0];
    desc.stride = {hi[STRIDE_HI_W-1:0], lo[WORD_W-1:BASE_W]};
    desc.height = hi[HEIGHT_LSB +: HEIGHT_W];
    desc.wrap   = hi[WRAP_LSB +: WRAP_W];
    desc.tile   = hi[TILE_LSB +: TILE_W];
    desc.swap   = hi[SWAP_LSB +: SWAP_W];
  end
endmodule

// File: rtl/pixbuf_desc_table.sv
module pixbuf_desc_table
  import pbd_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int ADDR_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [WORD_W-1:0]   bus_wdata,
  output logic [WORD_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [IDX_W-1:0]    lk_idx,
  output logic [BASE_W-1:0]   lk_base,
  output logic [STRIDE_W-1:0] lk_stride,
  output logic [HEIGHT_W-1:0] lk_height,
  output logic [WRAP_W-1:0]   lk_wrap,
  output logic [TILE_W-1:0]   lk_tile,
  output logic [SWAP_W-1:0]   lk_swap
);
  logic               commit;
  logic [IDX_W-1:0]   cmd_idx;
  logic [ENTRY_W-1:0] stage_word;
  logic [ENTRY_W-1:0] fetch_word;
  logic [ENTRY_W-1:0] look_word;
  logic [IDX_W-1:0]   lk_idx_q;
  desc_t              look_desc;

  pbd_stage_regs #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_stage (
    .clk(clk), .rst(rst),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .commit(commit), .cmd_idx(cmd_idx),
    .stage_word(stage_word), .fetch_word(fetch_word)
  );

  pbd_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(commit), .wr_idx(cmd_idx), .wr_data(stage_word),
    .a_idx(cmd_idx), .a_data(fetch_word),
    .b_idx(lk_idx_q), .b_data(look_word)
  );

  always_ff @(posedge clk) begin
    if (rst) lk_idx_q <= '0;
    else     lk_idx_q <= lk_idx;
  end

  pbd_field_decode u_dec (.word(look_word), .desc(look_desc));

  assign lk_base   = look_desc.base;
  assign lk_stride = look_desc.stride;
  assign lk_height = look_desc.height;
  assign lk_wrap   = look_desc.wrap;
  assign lk_tile   = look_desc.tile;
  assign lk_swap   = look_desc.swap;

  // R8
  lookup_commit_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && cmd_idx == lk_idx && !$isunknown(stage_word)) |=> (look_word == $past(stage_word)));
endmodule

// File: tb/sim_pixbuf_desc_table.sv
module sim_pixbuf_desc_table;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  lk_idx = '0;
  logic [28:0] lk_base;
  logic [11:0] lk_stride;
  logic [12:0] lk_height;
  logic [1:0]  lk_wrap, lk_tile;
  logic [3:0]  lk_swap;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pixbuf_desc_table u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_of(logic [28:0] b, logic [11:0] s);
    return {s[2:0], b};
  endfunction
  function automatic logic [31:0] hi_of(logic [11:0] s, logic [12:0] h, logic [1:0] w,
                                        logic [1:0] t, logic [3:0] sw);
    return {2'b00, sw, t, w, h, s[11:3]};
  endfunction
  function automatic logic [63:0] fld(logic [28:0] b, logic [11:0] s, logic [12:0] h,
                                      logic [1:0] w, logic [1:0] t, logic [3:0] sw);
    return {2'b00, b, s, h, w, t, sw};
  endfunction
  function automatic logic [63:0] look_now();
    return {2'b00, lk_base, lk_stride, lk_height, lk_wrap, lk_tile, lk_swap};
  endfunction

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    chk("R9 rvalid", {63'd0, bus_rvalid}, 64'd1);
  endtask

  task automatic look(logic [7:0] i, output logic [63:0] f);
    lk_idx = i;
    @(negedge clk);
    f = look_now();
  endtask

  task automatic put(logic [7:0] i, logic [28:0] b, logic [11:0] s, logic [12:0] h,
                     logic [1:0] w, logic [1:0] t, logic [3:0] sw);
    bus_write(4'h0, lo_of(b, s));
    bus_write(4'h4, hi_of(s, h, w, t, sw));
    bus_write(4'h8, {22'd0, 2'b10, i});
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [63:0] f;
    bus_read(4'h0, d); chk("R1 stage lo", {32'd0, d}, 64'd0);
    bus_read(4'h4, d); chk("R1 stage hi", {32'd0, d}, 64'd0);
    look(8'd0, f);   chk("R1 entry 0", f, 64'd0);
    look(8'd255, f); chk("R1 entry 255", f, 64'd0);
  endtask

  task automatic t_stage();
    logic [31:0] d;
    bus_write(4'h0, 32'hDEAD_BEEF);
    bus_write(4'h4, 32'hFFFF_FFFF);
    bus_read(4'h0, d); chk("R2 lo readback", {32'd0, d}, 64'hDEAD_BEEF);
    bus_read(4'h4, d); chk("R2 hi unused zero", {32'd0, d}, 64'h3FFF_FFFF);
    bus_read(4'h8, d); chk("R2 cmd reads zero", {32'd0, d}, 64'd0);
  endtask

  task automatic t_commit();
    logic [63:0] f;
    put(8'd5, 29'h1234_567, 12'hABC, 13'h0438, 2'd1, 2'd2, 4'h7);
    look(8'd5, f); chk("R3 entry 5", f, fld(29'h1234_567, 12'hABC, 13'h0438, 2'd1, 2'd2, 4'h7));
    put(8'd0, 29'h1FFF_FFFF, 12'hFFF, 13'h1FFF, 2'd2, 2'd1, 4'hF);
    look(8'd0, f); chk("R4 entry 0 stride fff", f, fld(29'h1FFF_FFFF, 12'hFFF, 13'h1FFF, 2'd2, 2'd1, 4'hF));
    put(8'd255, 29'h0000_010, 12'h007, 13'd720, 2'd0, 2'd0, 4'h1);
    look(8'd255, f); chk("R4 entry 255 stride 7", f, fld(29'h10, 12'h007, 13'd720, 2'd0, 2'd0, 4'h1));
    put(8'd254, 29'h0ABC_DEF, 12'h008, 13'd1080, 2'd1, 2'd1, 4'h3);
    look(8'd254, f); chk("R4 entry 254 stride 8", f, fld(29'h0ABC_DEF, 12'h008, 13'd1080, 2'd1, 2'd1, 4'h3));
  endtask

  task automatic t_readback();
    logic [31:0] d;
    bus_write(4'h0, 32'h1111_1111);
    bus_write(4'h4, 32'h2222_2222);
    bus_write(4'h8, {22'd0, 2'b01, 8'd5});
    bus_read(4'h0, d); chk("R5 load lo", {32'd0, d}, {32'd0, lo_of(29'h1234_567, 12'hABC)});
    bus_read(4'h4, d); chk("R5 load hi", {32'd0, d}, {32'd0, hi_of(12'hABC, 13'h0438, 2'd1, 2'd2, 4'h7)});
    bus_write(4'h8, {22'd0, 2'b01, 8'd77});
    bus_read(4'h0, d); chk("R1 unwritten entry lo", {32'd0, d}, 64'd0);
    bus_read(4'h4, d); chk("R1 unwritten entry hi", {32'd0, d}, 64'd0);
  endtask

  task automatic t_both();
    logic [31:0] d; logic [63:0] f;
    bus_write(4'h0, lo_of(29'h0777_000, 12'h123));
    bus_write(4'h4, hi_of(12'h123, 13'd99, 2'd2, 2'd2, 4'h7));
    bus_write(4'h8, {22'd0, 2'b11, 8'd9});
    bus_read(4'h0, d); chk("R6 stage lo kept", {32'd0, d}, {32'd0, lo_of(29'h0777_000, 12'h123)});
    bus_read(4'h4, d); chk("R6 stage hi kept", {32'd0, d}, {32'd0, hi_of(12'h123, 13'd99, 2'd2, 2'd2, 4'h7)});
    look(8'd9, f); chk("R6 entry 9 committed", f, fld(29'h0777_000, 12'h123, 13'd99, 2'd2, 2'd2, 4'h7));
  endtask

  task automatic t_idle();
    logic [31:0] d; logic [63:0] f;
    bus_write(4'h0, 32'h0BAD_CAFE);
    bus_write(4'h8, {22'd0, 2'b00, 8'd5});
    look(8'd5, f); chk("R7 entry 5 unchanged", f, fld(29'h1234_567, 12'hABC, 13'h0438, 2'd1, 2'd2, 4'h7));
    bus_read(4'h0, d); chk("R7 stage lo unchanged", {32'd0, d}, 64'h0BAD_CAFE);
  endtask

  task automatic t_lookup_reg();
    logic [63:0] f;
    look(8'd5, f);
    lk_idx = 8'd9;
    #2;
    chk("R8 index registered", look_now(), fld(29'h1234_567, 12'hABC, 13'h0438, 2'd1, 2'd2, 4'h7));
    @(negedge clk);
    chk("R8 new index shown", look_now(), fld(29'h0777_000, 12'h123, 13'd99, 2'd2, 2'd2, 4'h7));
  endtask

  task automatic t_flush();
    logic [63:0] f;
    look(8'd5, f);
    bus_write(4'h0, lo_of(29'h0055_AA0, 12'h3C5));
    bus_write(4'h4, hi_of(12'h3C5, 13'd480, 2'd0, 2'd1, 4'hF));
    bus_addr = 4'h8; bus_wdata = {22'd0, 2'b10, 8'd5}; bus_wr = 1'b1;
    #2;
    chk("R8 old entry before commit edge", look_now(), fld(29'h1234_567, 12'hABC, 13'h0438, 2'd1, 2'd2, 4'h7));
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 4'h4; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk("R9 rvalid after barrier read", {63'd0, bus_rvalid}, 64'd1);
    chk("R9 barrier data", {32'd0, bus_rdata}, {32'd0, hi_of(12'h3C5, 13'd480, 2'd0, 2'd1, 4'hF)});
    chk("R9 commit visible at answer", look_now(), fld(29'h0055_AA0, 12'h3C5, 13'd480, 2'd0, 2'd1, 4'hF));
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_stage();
    t_commit();
    t_readback();
    t_both();
    t_idle();
    t_lookup_reg();
    t_flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule